// File: doc/BRIEF.md
# Programmable UART Baud Tick Generator

This block produces the bit-rate timing for a serial port. An 8-bit down counter, reloaded from a software-written divisor X, divides the system clock by X+1 and emits a stage pulse. A prescaler then divides the stage pulses by 64, 16 or 4. The divide ratio is chosen by two mode bits: asynchronous low speed, asynchronous high speed, or synchronous. The prescaler output is the one-cycle baud tick. The stage pulse itself is brought out as a one-cycle sub-bit tick, which a receiver can use to time its oversampling.

A divisor write restarts the timing chain at once, so the new rate takes effect without waiting for the old period to finish. A change of the effective mode does the same. A small controller has two states. ST_HOLD is entered while enable is low; there the chain is held cleared and no ticks appear. ST_RUN is the counting state. The transitions are as follows. *arm* (ST_HOLD to ST_RUN, when enable is high) loads the counter. *disarm* (ST_RUN to ST_HOLD, when enable drops) clears the chain. *restart* (ST_RUN to ST_RUN, on a divisor write or an effective mode change) reloads the counter and clears the prescaler. *count* (ST_RUN to ST_RUN) is the normal case.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both ticks are low, the divisor is 0 and the mode is asynchronous low speed, so enabling gives a baud period of 64 clocks.
- R2: With sync_mode=0 and high_speed=0 the baud tick period is 64×(X+1) clocks.
- R3: With sync_mode=0 and high_speed=1 the baud tick period is 16×(X+1) clocks.
- R4: With sync_mode=1 the baud tick period is 4×(X+1) clocks.
- R5: When sync_mode stays 1, toggling high_speed changes neither the period nor the phase of the baud tick.
- R6: If divisor_we is high in cycle t, the next baud tick occurs in cycle t+N×(X+1). Here N is the mode ratio and X is the written value. This holds wherever cycle t falls within the old period.
- R7: If the effective mode changes in cycle t and no write occurs, the next baud tick occurs in cycle t+N×(X+1), using the new ratio N.
- R8: While enable is low, no tick occurs, and divisor writes are still stored. If enable first goes high in cycle e, the first baud tick occurs in cycle e+N×(X+1).
- R9: The sub-bit tick repeats every X+1 clocks. Every baud tick coincides with a sub-bit tick, and there are exactly N sub-bit ticks per baud period.
- R10: A divisor write in the very cycle where a tick would fire suppresses both ticks in that cycle, and the restart of R6 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high |
| divisor_wdata | input | 8 | New divisor value X |
| divisor_we | input | 1 | Write strobe for divisor_wdata |
| sync_mode | input | 1 | 1 selects synchronous ratio 4 |
| high_speed | input | 1 | In asynchronous mode, 1 selects ratio 16 and 0 selects ratio 64 |
| baud_tick | output | 1 | One-cycle pulse once per bit period |
| sub_tick | output | 1 | One-cycle pulse every X+1 clocks |

## Verification
A divisor write and a tick can land in the same cycle. The bench provokes this by counting exactly one period after a baud tick and raising the write strobe in the cycle where the next tick is due. It then judges two things. First, that both ticks are absent in that cycle. Second, that the following baud tick comes exactly one full new period later. A mode change falling in the middle of a period is handled the same way: the distance to the next tick must equal the new period, not the remainder of the old one.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    typedef enum logic [1:0] {
        MODE_SLOW = 2'd0,
        MODE_FAST = 2'd1,
        MODE_SYNC = 2'd2
    } rate_mode_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    // In synchronous mode the speed bit plays no part.
    function automatic rate_mode_e decode_mode(input logic sync_bit, input logic fast_bit);
        if (sync_bit)
            return MODE_SYNC;
        else if (fast_bit)
            return MODE_FAST;
        else
            return MODE_SLOW;
    endfunction

endpackage

// File: rtl/baudgen_ctrl.sv
module baudgen_ctrl
    import baudgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       divisor_we,
    input  logic       sync_mode,
    input  logic       high_speed,
    output rate_mode_e mode_q,
    output logic       clear,
    output logic       load,
    output logic       count_en
);

    gen_state_e state_q, state_d;
    rate_mode_e mode_now;
    logic       mode_chg;

    assign mode_now = decode_mode(sync_mode, high_speed);
    assign mode_chg = (mode_now != mode_q);

    // State register and mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            mode_q  <= MODE_SLOW;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_now;
        end
    end

    // Next state: arm / disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs per state and transition
    always_comb begin
        clear    = 1'b0;
        load     = 1'b0;
        count_en = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (enable) load  = 1'b1;   // arm
                else        clear = 1'b1;
            end
            ST_RUN: begin
                if (!enable)                       clear    = 1'b1; // disarm
                else if (divisor_we || mode_chg)   load     = 1'b1; // restart
                else                               count_en = 1'b1; // count
            end
            default: clear = 1'b1;
        endcase
    end

endmodule

// File: rtl/baudgen_divider.sv
module baudgen_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] wdata,
    input  logic             we,
    input  logic             clear,
    input  logic             load,
    input  logic             count_en,
    output logic [DIV_W-1:0] cnt_q,
    output logic             stage_tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] load_val;

    // A write in the same cycle as a load takes effect at once.
    assign load_val = we ? wdata : div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (we)
            div_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (count_en)
            cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
    end

    assign stage_tick = count_en && (cnt_q == '0);

endmodule

// File: rtl/baudgen_prescaler.sv
module baudgen_prescaler
    import baudgen_pkg::*;
#(
    parameter int SLOW_RATIO = 64,
    parameter int FAST_RATIO = 16,
    parameter int SYNC_RATIO = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       stage_tick,
    input  rate_mode_e mode,
    output logic       baud_tick
);

    localparam int MAX_AF  = (SLOW_RATIO > FAST_RATIO) ? SLOW_RATIO : FAST_RATIO;
    localparam int MAX_R   = (MAX_AF > SYNC_RATIO) ? MAX_AF : SYNC_RATIO;
    localparam int PRE_W   = (MAX_R > 2) ? $clog2(MAX_R) : 1;

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] term;

    always_comb begin
        unique case (mode)
            MODE_SLOW: term = PRE_W'(SLOW_RATIO - 1);
            MODE_FAST: term = PRE_W'(FAST_RATIO - 1);
            MODE_SYNC: term = PRE_W'(SYNC_RATIO - 1);
            default:   term = PRE_W'(SYNC_RATIO - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pcnt_q <= '0;
        else if (stage_tick)
            pcnt_q <= (pcnt_q == term) ? '0 : pcnt_q + 1'b1;
    end

    assign baud_tick = stage_tick && (pcnt_q == term);

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import baudgen_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SLOW_RATIO = 64,
    parameter int FAST_RATIO = 16,
    parameter int SYNC_RATIO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor_wdata,
    input  logic             divisor_we,
    input  logic             sync_mode,
    input  logic             high_speed,
    output logic             baud_tick,
    output logic             sub_tick
);

    rate_mode_e       mode_q;
    logic             ctrl_clear;
    logic             ctrl_load;
    logic             ctrl_count;
    logic             stage_tick;
    logic [DIV_W-1:0] cnt_q;

    baudgen_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .divisor_we (divisor_we),
        .sync_mode  (sync_mode),
        .high_speed (high_speed),
        .mode_q     (mode_q),
        .clear      (ctrl_clear),
        .load       (ctrl_load),
        .count_en   (ctrl_count)
    );

    baudgen_divider #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata      (divisor_wdata),
        .we         (divisor_we),
        .clear      (ctrl_clear),
        .load       (ctrl_load),
        .count_en   (ctrl_count),
        .cnt_q      (cnt_q),
        .stage_tick (stage_tick)
    );

    baudgen_prescaler #(
        .SLOW_RATIO (SLOW_RATIO),
        .FAST_RATIO (FAST_RATIO),
        .SYNC_RATIO (SYNC_RATIO)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (ctrl_clear || ctrl_load),
        .stage_tick (stage_tick),
        .mode       (mode_q),
        .baud_tick  (baud_tick)
    );

    assign sub_tick = stage_tick;

endmodule

// File: rtl/baudgen_checker.sv
module baudgen_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [DIV_W-1:0] divisor_wdata,
    input logic             divisor_we,
    input logic             sync_mode,
    input logic             baud_tick,
    input logic             sub_tick,
    input logic [DIV_W-1:0] cnt_q,
    input logic             load
);

    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R9: a baud tick is always also a sub-bit tick
    p_baud_on_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sub_tick);

    // R8: disabled generator is silent
    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!sub_tick && !baud_tick));

    // R10: a write cycle carries no tick
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        divisor_we |-> (!sub_tick && !baud_tick));

    // R6: after a write while enabled, the counter starts from the new value
    p_reload_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_we && enable) |=> (cnt_q == $past(divisor_wdata)));

    // R5: speed bit toggles in synchronous mode cause no restart
    p_sync_hs_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sync_mode && $past(sync_mode) && $past(enable) && enable && !divisor_we)
        |-> !load);

endmodule

bind uart_baud_gen baudgen_checker #(.DIV_W(DIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .divisor_wdata (divisor_wdata),
    .divisor_we    (divisor_we),
    .sync_mode     (sync_mode),
    .baud_tick     (baud_tick),
    .sub_tick      (sub_tick),
    .cnt_q         (cnt_q),
    .load          (ctrl_load)
);

// File: tb/uart_baud_gen_test.sv
module uart_baud_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] divisor_wdata = '0;
    logic       divisor_we = 1'b0;
    logic       sync_mode = 1'b0;
    logic       high_speed = 1'b0;
    logic       baud_tick;
    logic       sub_tick;

    int  n_tests = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_baud_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .divisor_wdata (divisor_wdata),
        .divisor_we    (divisor_we),
        .sync_mode     (sync_mode),
        .high_speed    (high_speed),
        .baud_tick     (baud_tick),
        .sub_tick      (sub_tick)
    );

    // Table: {sync, high_speed}, X, expected period. R2 slow, R3 fast, R4 sync.
    localparam int NV = 9;
    localparam logic [1:0] T_MODE [NV] = '{2'b00, 2'b00, 2'b00,   // R2
                                           2'b01, 2'b01, 2'b01,   // R3
                                           2'b10, 2'b11, 2'b10};  // R4
    localparam int T_X [NV] = '{0, 25, 255, 0, 25, 255, 0, 25, 255};
    localparam int T_P [NV] = '{64, 1664, 16384, 16, 416, 4096, 4, 104, 1024};

    function automatic string req_of(input logic [1:0] m);
        if (m[1])      return "R4";
        else if (m[0]) return "R3";
        else           return "R2";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count cycles after the current one until a baud tick is seen.
    task automatic wait_baud(output int n);
        n = 0;
        do begin
            @(negedge clk);
            divisor_we = 1'b0;
            #1;
            n++;
        end while (!baud_tick && n < 20000);
    endtask

    task automatic write_cfg(input logic s, input logic h, input logic [7:0] x);
        @(negedge clk);
        sync_mode     = s;
        high_speed    = h;
        divisor_wdata = x;
        divisor_we    = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
            $finish;
        end
    end

    initial begin
        int n;
        int subs;
        int gap;
        bit gap_ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!baud_tick && !sub_tick, "R1", "ticks idle after reset", {baud_tick, sub_tick}, 0);

        // R1: default divisor 0, slow mode
        @(negedge clk);
        enable = 1'b1;
        wait_baud(n);
        check(n == 64, "R1", "first period from reset defaults", n, 64);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            write_cfg(T_MODE[i][1], T_MODE[i][0], 8'(T_X[i]));
            wait_baud(n);
            check(n == T_P[i], req_of(T_MODE[i]), "first period after write", n, T_P[i]);
            wait_baud(n);
            check(n == T_P[i], req_of(T_MODE[i]), "steady period", n, T_P[i]);
        end

        // R6: write in mid period restarts
        write_cfg(1'b0, 1'b0, 8'd10);
        repeat (100) @(negedge clk);
        write_cfg(1'b0, 1'b0, 8'd2);
        wait_baud(n);
        check(n == 192, "R6", "mid-period write restarts", n, 192);

        // R10: write in the tick cycle
        write_cfg(1'b0, 1'b1, 8'd3);
        wait_baud(n);
        repeat (63) @(negedge clk);
        @(negedge clk);
        divisor_wdata = 8'd1;
        divisor_we    = 1'b1;
        #1;
        check(!baud_tick && !sub_tick, "R10", "tick suppressed by write", {baud_tick, sub_tick}, 0);
        wait_baud(n);
        check(n == 32, "R10", "full new period after colliding write", n, 32);

        // R7: mode change in mid period
        write_cfg(1'b0, 1'b1, 8'd3);
        wait_baud(n);
        repeat (10) @(negedge clk);
        @(negedge clk);
        sync_mode = 1'b1;
        wait_baud(n);
        check(n == 16, "R7", "mode change restarts with new ratio", n, 16);

        // R5: speed bit toggles in sync mode
        wait_baud(n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 5) high_speed = 1'b0;
            if (n == 9) high_speed = 1'b1;
            #1;
        end while (!baud_tick && n < 20000);
        check(n == 16, "R5", "speed bit ignored in sync mode", n, 16);

        // R8: disabled, write still stored, re-arm
        @(negedge clk);
        enable = 1'b0;
        divisor_wdata = 8'd1;
        divisor_we    = 1'b1;
        subs = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            divisor_we = 1'b0;
            #1;
            if (baud_tick || sub_tick) subs++;
        end
        check(subs == 0, "R8", "no ticks while disabled", subs, 0);
        @(negedge clk);
        enable = 1'b1;
        wait_baud(n);
        check(n == 8, "R8", "first period after enable", n, 8);

        // R9: sub-tick spacing and count per baud period
        write_cfg(1'b0, 1'b1, 8'd2);
        wait_baud(n);
        subs = 0; gap = 0; gap_ok = 1'b1;
        do begin
            @(negedge clk); #1;
            gap++;
            if (sub_tick) begin
                subs++;
                if (gap != 3) gap_ok = 1'b0;
                gap = 0;
            end
        end while (!baud_tick && subs < 1000);
        check(subs == 16, "R9", "sub ticks per baud period", subs, 16);
        check(gap_ok, "R9", "sub tick spacing ok", gap_ok, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
        $finish;
    end

endmodule